// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a register-mapped timer that software can turn into a watchdog for the device. It holds a 64-bit up-counter and a 64-bit period. Each is reached as two 32-bit registers. A global control register sets the operating mode, releases the counter halves and sets a clock divider. Once the watchdog is armed, software must keep resetting the counter with an ordered pair of key writes. If it fails to do so, the counter climbs to the period and the block pulses its device-reset request.

The key handshake is strict. Any key value that does not match the step the handshake is waiting for raises the reset request at once; it is not ignored. Firmware can use this on purpose to force an immediate device reset by writing a bad key. After a pulse the block stays quiet with its counter frozen until the device reset comes back in on `rst_n`, which returns every register to its default and disarms the watchdog.

Top module: `wdog_keyed_timer`

## Requirements
- R1: After `rst_n` every register reads 0, the watchdog is disarmed and `wdog_rst_req` is 0.
- R2: Byte offsets are: counter low 0x10, counter high 0x14, period low 0x18, period high 0x1C, timer control 0x20, global control 0x24, watchdog control 0x28. While disarmed, all of them read back what was written, except watchdog control, which reads the arm flag at bit 14 and 0 elsewhere.
- R3: The counter advances only when the watchdog is armed, global control bits 1:0 are both 1 and bits 3:2 equal 2 (value 0x0B). It adds one per tick across all 64 bits, with carry from the low half into the high half.
- R4: Global control bits 11:8 hold N. A counter tick occurs once every N+1 clocks while counting.
- R5: When a counting counter equals the 64-bit period, `wdog_rst_req` is high for exactly one cycle, starting in the cycle after the match, and the counter holds its value.
- R6: A write to watchdog control with bit 14 set arms the watchdog. Arming is sticky: later writes with bit 14 clear leave it armed.
- R7: While disarmed, a write to watchdog control with bit 14 clear has no effect: no reset request and no arming.
- R8: The key field is bits 31:16. Key 0xA5C6 followed by key 0xDA7E services the watchdog. The counter reads 0 in the second cycle after the 0xDA7E write, and the handshake then waits for 0xA5C6 again.
- R9: Any key other than the one expected at the current step is a violation. This includes the arming write itself and a repeated 0xA5C6. A violation raises `wdog_rst_req` in the next cycle.
- R10: While armed, writes to the counter and period registers are ignored.
- R11: After one reset pulse, no further pulse occurs and the counter stays frozen until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| wdog_rst_req | output | 1 | One-cycle device reset request |

## Verification
The hardest condition to reach from the ports is the carry from the low counter half into the high half that lands exactly on a period whose low word is zero. Counting there from reset would take billions of cycles. The bench instead preloads the low counter half with all ones and sets the period to 2^32 while disarmed, then arms. It checks the low half, then the high half, then the reset pulse, each in a computed cycle. The handshake ordering is reached in the same cycle-exact way: a service in the middle of counting is followed by a repeated first key.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam logic [7:0] OFS_CNT_LO = 8'h10;
   localparam logic [7:0] OFS_CNT_HI = 8'h14;
   localparam logic [7:0] OFS_PRD_LO = 8'h18;
   localparam logic [7:0] OFS_PRD_HI = 8'h1C;
   localparam logic [7:0] OFS_TCTL   = 8'h20;
   localparam logic [7:0] OFS_GCTL   = 8'h24;
   localparam logic [7:0] OFS_WCTL   = 8'h28;

   localparam int unsigned ARM_BIT   = 14;
   localparam int unsigned KEY_W     = 16;
   localparam int unsigned DIV_LSB   = 8;
   localparam logic [1:0]  MODE_WDOG = 2'd2;

   localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6;
   localparam logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E;

   typedef enum logic {
      STEP_FIRST,
      STEP_SECOND
   } key_step_e;

endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
   parameter int unsigned DIV_W  = 4,
   parameter bit          DIV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
      $error("wdt_tick_div: DIV_W out of range");
   end

   if (DIV_EN) begin : g_div
      logic [DIV_W-1:0] pre_q;

      assign tick = run && (pre_q == div);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pre_q <= '0;
         else if (!run)   pre_q <= '0;
         else if (tick)   pre_q <= '0;
         else             pre_q <= pre_q + 1'b1;
      end

      // R4: after a tick the next one is at least N+1 clocks away
      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> (!tick || div == '0));
   end else begin : g_nodiv
      logic unused_div;
      assign unused_div = ^div;
      assign tick = run;
   end

endmodule

// File: rtl/wdt_count_bank.sv
module wdt_count_bank #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              clr,
   input  logic              lock,
   input  logic              wr_cnt,
   input  logic              wr_prd,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wr_data,
   output logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  prd,
   output logic              hit
);

   localparam int unsigned NUM_HALF = CNT_W / DATA_W;

   if (NUM_HALF < 1 || NUM_HALF > 2 || NUM_HALF * DATA_W != CNT_W) begin : g_bad_split
      $error("wdt_count_bank: CNT_W must be one or two DATA_W words");
   end

   logic [NUM_HALF:0] carry;
   assign carry[0] = inc;

   for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
      logic [DATA_W-1:0] cnt_h_q;
      logic [DATA_W-1:0] prd_h_q;
      logic              sel_h;

      assign sel_h        = (h == int'(wr_hi));
      assign carry[h+1]   = carry[h] && (&cnt_h_q);
      assign cnt[h*DATA_W +: DATA_W] = cnt_h_q;
      assign prd[h*DATA_W +: DATA_W] = prd_h_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          cnt_h_q <= '0;
         else if (clr)                        cnt_h_q <= '0;
         else if (wr_cnt && !lock && sel_h)   cnt_h_q <= wr_data;
         else if (carry[h])                   cnt_h_q <= cnt_h_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                          prd_h_q <= '0;
         else if (wr_prd && !lock && sel_h)   prd_h_q <= wr_data;
      end
   end

   assign hit = (cnt == prd);

   // R8: a service clear lands one cycle after the strobe
   a_r8_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // R3: an undisturbed increment moves the whole 64-bit value by one
   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr && !(wr_cnt && !lock)) |=> (cnt == $past(cnt) + 1'b1));

   // R10: period cannot move while the watchdog is armed
   a_r10_prd_locked: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(prd));

   // R10: counter moves only by counting or clearing while armed
   a_r10_cnt_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (lock && !inc && !clr) |=> $stable(cnt));

endmodule

// File: rtl/wdt_key_guard.sv
module wdt_key_guard
   import wdt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wctl_wr,
   input  logic             arm_bit,
   input  logic [KEY_W-1:0] key,
   output logic             armed,
   output logic             violation,
   output logic             clr_pulse
);

   key_step_e step_q, step_d;
   logic      armed_q;
   logic      clr_q;
   logic      armed_next;
   logic      judged;
   logic      good_first;
   logic      good_second;

   assign armed_next  = armed_q || (wctl_wr && arm_bit);
   assign judged      = wctl_wr && armed_next;
   assign good_first  = (step_q == STEP_FIRST)  && (key == KEY_FIRST);
   assign good_second = (step_q == STEP_SECOND) && (key == KEY_SECOND);
   assign violation   = judged && !good_first && !good_second;

   always_comb begin
      step_d = step_q;
      if (judged) begin
         if (good_first) step_d = STEP_SECOND;
         else            step_d = STEP_FIRST;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q  <= STEP_FIRST;
         armed_q <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         step_q  <= step_d;
         armed_q <= armed_next;
         clr_q   <= judged && good_second;
      end
   end

   assign armed     = armed_q;
   assign clr_pulse = clr_q;

   // R6: once armed, only rst_n disarms
   a_r6_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |=> armed_q);

   // R7: disarmed write without the arm bit leaves the handshake untouched
   a_r7_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && wctl_wr && !arm_bit) |=> (!armed_q && step_q == $past(step_q)));

   // R8: after a service the handshake waits for the first key
   a_r8_back_to_first: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |-> (step_q == STEP_FIRST));

endmodule

// File: rtl/wdog_keyed_timer.sv
module wdog_keyed_timer
   import wdt_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned DIV_W  = 4,
   parameter bit          DIV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              wdog_rst_req
);

   localparam int unsigned NUM_HALF = CNT_W / DATA_W;

   if (DATA_W < 32) begin : g_bad_data_w
      $error("wdog_keyed_timer: DATA_W must hold the key field and arm bit");
   end
   if (ADDR_W < 6) begin : g_bad_addr_w
      $error("wdog_keyed_timer: ADDR_W too small for the register map");
   end
   if (DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
      $error("wdog_keyed_timer: divider field exceeds register");
   end

   logic              wr;
   logic              hit_cnt, hit_prd, hit_tctl, hit_gctl, hit_wctl;
   logic [DATA_W-1:0] tctl_q, gctl_q;
   logic              armed, violation, clr_pulse;
   logic              run, tick, match, inc, trip;
   logic              fired_q, req_q;
   logic [CNT_W-1:0]  cnt, prd;
   logic [DATA_W-1:0] cnt_lo, cnt_hi, prd_lo, prd_hi;

   assign wr       = bus_sel && bus_wr;
   assign hit_cnt  = (bus_addr == ADDR_W'(OFS_CNT_LO)) || (bus_addr == ADDR_W'(OFS_CNT_HI));
   assign hit_prd  = (bus_addr == ADDR_W'(OFS_PRD_LO)) || (bus_addr == ADDR_W'(OFS_PRD_HI));
   assign hit_tctl = (bus_addr == ADDR_W'(OFS_TCTL));
   assign hit_gctl = (bus_addr == ADDR_W'(OFS_GCTL));
   assign hit_wctl = (bus_addr == ADDR_W'(OFS_WCTL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tctl_q <= '0;
         gctl_q <= '0;
      end else begin
         if (wr && hit_tctl) tctl_q <= bus_wdata;
         if (wr && hit_gctl) gctl_q <= bus_wdata;
      end
   end

   wdt_key_guard i_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .wctl_wr   (wr && hit_wctl),
      .arm_bit   (bus_wdata[ARM_BIT]),
      .key       (bus_wdata[DATA_W-1 -: KEY_W]),
      .armed     (armed),
      .violation (violation),
      .clr_pulse (clr_pulse)
   );

   assign run = armed && !fired_q && (gctl_q[1:0] == 2'b11) && (gctl_q[3:2] == MODE_WDOG);

   wdt_tick_div #(.DIV_W(DIV_W), .DIV_EN(DIV_EN)) i_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .div   (gctl_q[DIV_LSB +: DIV_W]),
      .tick  (tick)
   );

   assign inc = tick && !match;

   wdt_count_bank #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc     (inc),
      .clr     (clr_pulse),
      .lock    (armed),
      .wr_cnt  (wr && hit_cnt),
      .wr_prd  (wr && hit_prd),
      .wr_hi   (bus_addr[2]),
      .wr_data (bus_wdata),
      .cnt     (cnt),
      .prd     (prd),
      .hit     (match)
   );

   assign trip = !fired_q && (violation || (run && match));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fired_q <= 1'b0;
         req_q   <= 1'b0;
      end else begin
         fired_q <= fired_q || trip;
         req_q   <= trip;
      end
   end

   assign wdog_rst_req = req_q;

   assign cnt_lo = cnt[DATA_W-1:0];
   assign prd_lo = prd[DATA_W-1:0];
   if (NUM_HALF == 2) begin : g_two_half
      assign cnt_hi = cnt[CNT_W-1 -: DATA_W];
      assign prd_hi = prd[CNT_W-1 -: DATA_W];
   end else begin : g_one_half
      assign cnt_hi = '0;
      assign prd_hi = '0;
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFS_CNT_LO): bus_rdata = cnt_lo;
         ADDR_W'(OFS_CNT_HI): bus_rdata = cnt_hi;
         ADDR_W'(OFS_PRD_LO): bus_rdata = prd_lo;
         ADDR_W'(OFS_PRD_HI): bus_rdata = prd_hi;
         ADDR_W'(OFS_TCTL):   bus_rdata = tctl_q;
         ADDR_W'(OFS_GCTL):   bus_rdata = gctl_q;
         ADDR_W'(OFS_WCTL):   bus_rdata[ARM_BIT] = armed;
         default:             bus_rdata = '0;
      endcase
   end

   // R5: the reset request never lasts more than one cycle
   a_r5_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_rst_req |=> !wdog_rst_req);

   // R11: once a pulse has been sent the output stays low
   a_r11_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !wdog_rst_req) |=> !wdog_rst_req);

   // R11: after a pulse the counter no longer advances
   a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (fired_q && !clr_pulse) |=> $stable(cnt));

endmodule

// File: tb/test_wdog_keyed_timer.sv
module test_wdog_keyed_timer;

   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          wdog_rst_req;

   always #10 clk = ~clk;

   wdog_keyed_timer i_wdog_keyed_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .wdog_rst_req (wdog_rst_req)
   );

   typedef struct {
      string       tag;
      logic [31:0] exp;
      bit          is_req;
   } exp_item_t;

   exp_item_t sb_q[$];
   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   // Monitor: compares mid-cycle, away from the clock edge
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_item_t it;
         logic [31:0] act;
         it = sb_q.pop_front();
         act = it.is_req ? {31'b0, wdog_rst_req} : bus_rdata;
         checks++;
         if (act !== it.exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      step();
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
      exp_item_t it;
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      it.tag = tag; it.exp = e; it.is_req = 1'b0;
      sb_q.push_back(it);
      step();
      bus_sel = 1'b0;
   endtask

   task automatic req_exp(input bit e, input string tag);
      exp_item_t it;
      it.tag = tag; it.exp = {31'b0, e}; it.is_req = 1'b1;
      sb_q.push_back(it);
      step();
   endtask

   task automatic dev_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   initial begin
      idle(2);
      rst_n = 1'b1;
      idle(1);

      // R1: defaults
      rd_exp(8'h28, 32'h0, "R1 wctl");
      rd_exp(8'h24, 32'h0, "R1 gctl");
      rd_exp(8'h10, 32'h0, "R1 cnt_lo");
      rd_exp(8'h1C, 32'h0, "R1 prd_hi");
      req_exp(1'b0, "R1 req");

      // R2: map and readback while disarmed
      wr_reg(8'h20, 32'hDEADBEEF);
      rd_exp(8'h20, 32'hDEADBEEF, "R2 tctl");
      wr_reg(8'h18, 32'h12345678);
      rd_exp(8'h18, 32'h12345678, "R2 prd_lo");
      wr_reg(8'h14, 32'h0000A5A5);
      rd_exp(8'h14, 32'h0000A5A5, "R2 cnt_hi");
      wr_reg(8'h24, 32'h0000030B);
      rd_exp(8'h24, 32'h0000030B, "R2 gctl");

      // R7: key write without arm bit while disarmed
      wr_reg(8'h28, 32'h12340000);
      req_exp(1'b0, "R7 no req a");
      req_exp(1'b0, "R7 no req b");
      rd_exp(8'h28, 32'h0, "R7 still disarmed");

      // R3: armed but not in watchdog mode does not count
      dev_reset();
      wr_reg(8'h24, 32'h00000003);
      wr_reg(8'h28, 32'hA5C64000);
      idle(3);
      rd_exp(8'h10, 32'h0, "R3 mode gate");

      // R8: service in the middle of counting
      dev_reset();
      wr_reg(8'h24, 32'h0000000B);
      wr_reg(8'h18, 32'd100);
      wr_reg(8'h28, 32'hA5C64000);
      idle(3);
      wr_reg(8'h28, 32'hDA7E4000);
      rd_exp(8'h10, 32'd4, "R8 before clear");
      rd_exp(8'h10, 32'd0, "R8 cleared");
      rd_exp(8'h10, 32'd1, "R3 counts on");
      wr_reg(8'h28, 32'hA5C64000);
      wr_reg(8'h28, 32'hDA7E4000);
      req_exp(1'b0, "R8 second round ok");
      rd_exp(8'h10, 32'd0, "R8 second clear");

      // R6: arm bit sticky
      wr_reg(8'h28, 32'hA5C60000);
      rd_exp(8'h28, 32'h00004000, "R6 sticky");
      wr_reg(8'h28, 32'hDA7E0000);
      req_exp(1'b0, "R6 keys still ok");

      // R10: period locked
      wr_reg(8'h18, 32'd7);
      rd_exp(8'h18, 32'd100, "R10 prd locked");

      // R9: repeated first key
      wr_reg(8'h28, 32'hA5C64000);
      wr_reg(8'h28, 32'hA5C64000);
      req_exp(1'b1, "R9 repeated first key");
      req_exp(1'b0, "R11 pulse ends");

      // R5: timeout on period 5
      dev_reset();
      wr_reg(8'h24, 32'h0000000B);
      wr_reg(8'h18, 32'd5);
      wr_reg(8'h28, 32'hA5C64000);
      for (int i = 0; i < 6; i++) req_exp(1'b0, "R5 before match");
      req_exp(1'b1, "R5 pulse");
      for (int i = 0; i < 3; i++) req_exp(1'b0, "R11 no repeat");
      rd_exp(8'h10, 32'd5, "R11 frozen");
      wr_reg(8'h10, 32'd0);
      rd_exp(8'h10, 32'd5, "R10 cnt locked");

      // R9: bad key on the arming write
      dev_reset();
      wr_reg(8'h28, 32'h12344000);
      req_exp(1'b1, "R9 bad arm key");
      req_exp(1'b0, "R9 pulse ends");
      rd_exp(8'h28, 32'h00004000, "R6 armed by write");

      // R4: divide by four
      dev_reset();
      wr_reg(8'h24, 32'h0000030B);
      wr_reg(8'h18, 32'd1000);
      wr_reg(8'h28, 32'hA5C64000);
      idle(7);
      rd_exp(8'h10, 32'd1, "R4 first tick");
      rd_exp(8'h10, 32'd2, "R4 second tick");

      // R3/R5: carry into high half landing on period 2^32
      dev_reset();
      wr_reg(8'h10, 32'hFFFFFFFF);
      wr_reg(8'h1C, 32'd1);
      wr_reg(8'h24, 32'h0000000B);
      wr_reg(8'h28, 32'hA5C64000);
      rd_exp(8'h10, 32'hFFFFFFFF, "R3 low full");
      rd_exp(8'h14, 32'd1, "R3 carry");
      req_exp(1'b1, "R5 64-bit match");

      idle(2);
      if (sb_q.size() != 0) begin
         errors++;
         checks++;
         $display("FAIL scoreboard: actual=%0d expected=0 pending", sb_q.size());
      end
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule